// File: doc/BRIEF.md
# Serial DAC Input Register Interface

This block is the digital front end of a 10-bit voltage-output converter. A host writes a code over a three-wire slave port: an active-low select, a serial clock that idles low, and a data line. While the select is low, each rising serial-clock edge shifts one bit into a 16-bit input register, most significant bit first. A frame starts with four filler bits, then carries the ten code bits, and ends with two zero bits below the code LSB. When the select returns high, the ten code bits are copied into a holding register. That register drives the parallel code to the converter.

The serial pins are not used as clocks. The select, serial clock and data lines each pass through a two-flop synchronizer onto a system clock that runs at least four times faster than the serial clock, and all edges are found from those samples. The top of the input register is driven out on a serial output pin on each falling serial-clock edge. This lets several devices be chained, with one device's output feeding the next device's data input. A power-on reset and an asynchronous active-low clear both force the holding register to zero. The clear acts whatever state the select is in. A saturating count of the bits in the current frame is also brought out.

Top module: `serdac_front`

## Requirements
- R1: While rst_ni is low, code_o is 0, sdo_o is 0, bit_cnt_o is 0 and the input register is zero.
- R2: While cs_ni is high, serial-clock edges shift no bits into the input register. A later select pulse with no clock edges loads the code from the earlier frame again.
- R3: On a rising edge of cs_ni, code_o takes bits [11:2] of the input register, where bit 15 is the first bit shifted in. The four filler bits (15:12) and the two trailing bits (1:0) have no effect on code_o.
- R4: code_o changes only after a rising edge of cs_ni, or through clear or reset. It holds its value throughout a frame.
- R5: If a frame is shorter or longer than 16 bits, the load uses the last 16 bits shifted in. Older bits left in the register fill any positions the short frame did not reach.
- R6: Driving clr_ni low sets code_o to 0 at once, without waiting for a system-clock edge, whether cs_ni is low or high.
- R7: If clr_ni is low when cs_ni rises, code_o stays 0 and keeps that value after clr_ni is released.
- R8: While cs_ni is low, sdo_o takes bit 15 of the input register on each falling serial-clock edge, so a bit at sdi_i appears at sdo_o 16 clocks later, on a falling edge. While cs_ni is high, sdo_o holds its last value.
- R9: bit_cnt_o goes to 0 when cs_ni falls, counts rising serial-clock edges while cs_ni is low, saturates at 16, and holds after cs_ni rises.
- R10: In a chain of two devices, 32 bits in one select window leave the first 16 bits in the far device and the last 16 bits in the near device. Both code outputs change on the same system-clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 4x the serial clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| sclk_i | input | 1 | Serial clock, idles low |
| cs_ni | input | 1 | Active-low select |
| sdi_i | input | 1 | Serial data in, MSB first |
| clr_ni | input | 1 | Active-low asynchronous clear of the code register |
| sdo_o | output | 1 | Serial data out for chaining |
| code_o | output | 10 | Parallel code to the converter |
| bit_cnt_o | output | 5 | Saturating count of bits in the current frame |

## Verification
The hardest condition to reach from the ports is the timing across a chain. The far device captures the near device's serial output, and that output is itself re-timed through synchronizers, so a load can only be called correct if both code registers move on the same system-clock edge. The bench chains two instances and keeps a bit-level model of both input registers, fed the same way. It sends 32-bit windows and ordinary 16-bit frames, and watches every cycle after the select rises for one register moving without the other. Short, long and empty frames, clock toggling while deselected, and a clear held across the select's rising edge are driven as directed cases around random frames.

// File: rtl/serdac_pkg.sv
package serdac_pkg;
  typedef struct packed {
    logic cs;
    logic sclk;
    logic din;
  } pins_t;

  localparam pins_t PINS_IDLE = '{cs: 1'b1, sclk: 1'b0, din: 1'b0};
endpackage

// File: rtl/serdac_sync.sv
module serdac_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg <= {STAGES{RST_VAL}};
    else         stg <= {stg[STAGES-2:0], d_i};
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/serdac_edges.sv
module serdac_edges
  import serdac_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  pins_t pins_s_i,
  output logic  sclk_rise_o,
  output logic  sclk_fall_o,
  output logic  cs_rise_o,
  output logic  cs_fall_o,
  output logic  sel_o
);
  logic sclk_q, cs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= PINS_IDLE.sclk;
      cs_q   <= PINS_IDLE.cs;
    end else begin
      sclk_q <= pins_s_i.sclk;
      cs_q   <= pins_s_i.cs;
    end
  end

  assign sclk_rise_o = pins_s_i.sclk & ~sclk_q;
  assign sclk_fall_o = ~pins_s_i.sclk & sclk_q;
  assign cs_rise_o   = pins_s_i.cs & ~cs_q;
  assign cs_fall_o   = ~pins_s_i.cs & cs_q;
  assign sel_o       = ~pins_s_i.cs;
endmodule

// File: rtl/serdac_shifter.sv
module serdac_shifter #(
  parameter int FRAME_W = 16,
  localparam int CNT_W  = $clog2(FRAME_W + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sclk_rise_i,
  input  logic               sclk_fall_i,
  input  logic               cs_fall_i,
  input  logic               sel_i,
  input  logic               din_i,
  output logic [FRAME_W-1:0] shreg_o,
  output logic               sdo_o,
  output logic [CNT_W-1:0]   cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FRAME_W);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_o <= '0;
      sdo_o   <= 1'b0;
      cnt_o   <= '0;
    end else begin
      if (sclk_rise_i && sel_i) shreg_o <= {shreg_o[FRAME_W-2:0], din_i};
      if (sclk_fall_i && sel_i) sdo_o <= shreg_o[FRAME_W-1];
      if (cs_fall_i)                                   cnt_o <= '0;
      else if (sclk_rise_i && sel_i && cnt_o != CNT_MAX) cnt_o <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/serdac_hold.sv
module serdac_hold #(
  parameter int FRAME_W = 16,
  parameter int CODE_W  = 10,
  parameter int LEAD_W  = 4,
  localparam int TOP_POS = FRAME_W - LEAD_W - 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_ni,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] shreg_i,
  output logic [CODE_W-1:0]  code_o
);
  // clear is asynchronous and wins over a coincident load
  always_ff @(posedge clk_i or negedge rst_ni or negedge clr_ni) begin
    if (!rst_ni)      code_o <= '0;
    else if (!clr_ni) code_o <= '0;
    else if (load_i)  code_o <= shreg_i[TOP_POS -: CODE_W];
  end
endmodule

// File: rtl/serdac_front.sv
module serdac_front
  import serdac_pkg::*;
#(
  parameter int FRAME_W = 16,
  parameter int CODE_W  = 10,
  parameter int LEAD_W  = 4,
  parameter int SYNC_N  = 2,
  localparam int CNT_W  = $clog2(FRAME_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              sdi_i,
  input  logic              clr_ni,
  output logic              sdo_o,
  output logic [CODE_W-1:0] code_o,
  output logic [CNT_W-1:0]  bit_cnt_o
);
  pins_t pins_raw, pins_s;
  logic  sclk_rise, sclk_fall, cs_rise, cs_fall, sel;
  logic  cs_hi_s;
  logic [FRAME_W-1:0] shreg;

  assign pins_raw = '{cs: cs_ni, sclk: sclk_i, din: sdi_i};

  serdac_sync #(.W($bits(pins_t)), .STAGES(SYNC_N), .RST_VAL(PINS_IDLE)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_raw),
    .q_o   (pins_s)
  );

  assign cs_hi_s = pins_s.cs;

  serdac_edges u_edges (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pins_s_i   (pins_s),
    .sclk_rise_o(sclk_rise),
    .sclk_fall_o(sclk_fall),
    .cs_rise_o  (cs_rise),
    .cs_fall_o  (cs_fall),
    .sel_o      (sel)
  );

  serdac_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sclk_rise_i(sclk_rise),
    .sclk_fall_i(sclk_fall),
    .cs_fall_i  (cs_fall),
    .sel_i      (sel),
    .din_i      (pins_s.din),
    .shreg_o    (shreg),
    .sdo_o      (sdo_o),
    .cnt_o      (bit_cnt_o)
  );

  serdac_hold #(.FRAME_W(FRAME_W), .CODE_W(CODE_W), .LEAD_W(LEAD_W)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_ni (clr_ni),
    .load_i (cs_rise),
    .shreg_i(shreg),
    .code_o (code_o)
  );
endmodule

// File: rtl/serdac_front_chk.sv
module serdac_front_chk #(
  parameter int FRAME_W = 16,
  parameter int CODE_W  = 10,
  parameter int CNT_W   = 5
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               clr_ni,
  input logic               cs_hi_s,
  input logic               cs_rise,
  input logic               sdo_o,
  input logic [CODE_W-1:0]  code_o,
  input logic [CNT_W-1:0]   bit_cnt_o,
  input logic [FRAME_W-1:0] shreg
);
  assert_clear_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |-> code_o == '0);

  assert_cnt_sat_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt_o <= CNT_W'(FRAME_W));

  assert_load_only_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_ni && !$stable(code_o) |-> $past(cs_rise));

  assert_sdo_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_hi_s && $past(cs_hi_s) |-> $stable(sdo_o));

  assert_no_shift_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_hi_s |=> $stable(shreg));
endmodule

bind serdac_front serdac_front_chk #(
  .FRAME_W(FRAME_W), .CODE_W(CODE_W), .CNT_W(CNT_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .clr_ni   (clr_ni),
  .cs_hi_s  (cs_hi_s),
  .cs_rise  (cs_rise),
  .sdo_o    (sdo_o),
  .code_o   (code_o),
  .bit_cnt_o(bit_cnt_o),
  .shreg    (shreg)
);

// File: tb/serdac_front_test.sv
module serdac_front_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, din = 1'b0, clr_n = 1'b1;
  logic       sdo_near, sdo_far;
  logic [9:0] code_near, code_far;
  logic [4:0] cnt_near, cnt_far;

  serdac_front uut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .sdi_i(din),
    .clr_ni(clr_n), .sdo_o(sdo_near), .code_o(code_near), .bit_cnt_o(cnt_near));

  serdac_front uut_far (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .sdi_i(sdo_near),
    .clr_ni(clr_n), .sdo_o(sdo_far), .code_o(code_far), .bit_cnt_o(cnt_far));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;
  logic [15:0] m_near, m_far;
  logic        sdo_en, sdo_ef;
  logic [9:0]  c_en, c_ef;
  int          cnt_e;

  function automatic logic [9:0] code_of(logic [15:0] sr);
    return sr[11:2];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic model_reset();
    m_near = '0; m_far = '0; sdo_en = 1'b0; sdo_ef = 1'b0;
    c_en = '0; c_ef = '0; cnt_e = 0;
  endtask

  task automatic send_bit(logic b);
    din = b;
    wait_n(4);
    sclk = 1'b1;
    m_far  = {m_far[14:0], sdo_en};
    m_near = {m_near[14:0], b};
    if (cnt_e < 16) cnt_e++;
    wait_n(8);
    sclk = 1'b0;
    sdo_en = m_near[15];
    sdo_ef = m_far[15];
    wait_n(4);
    chk("R8 sdo near", sdo_near, sdo_en);
    chk("R8 sdo far", sdo_far, sdo_ef);
    chk("R4 code near in frame", code_near, c_en);
    chk("R4 code far in frame", code_far, c_ef);
    chk("R9 bit count", cnt_near, cnt_e);
  endtask

  task automatic sel_on();
    cs_n = 1'b0;
    wait_n(4);
    cnt_e = 0;
    chk("R9 count cleared", cnt_near, 0);
  endtask

  task automatic sel_off();
    logic [9:0] old_n, old_f, new_n, new_f;
    old_n = code_near; old_f = code_far;
    new_n = clr_n ? code_of(m_near) : '0;
    new_f = clr_n ? code_of(m_far)  : '0;
    cs_n = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (new_n != old_n && new_f != old_f)
        chk("R10 same-edge update", (code_near !== old_n), (code_far !== old_f));
    end
    c_en = new_n; c_ef = new_f;
    chk("R3 code near loaded", code_near, c_en);
    chk("R3 code far loaded", code_far, c_ef);
    chk("R9 count held", cnt_near, cnt_e);
  endtask

  task automatic send_bits(logic [31:0] v, int n);
    for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic frame(logic [15:0] f);
    sel_on();
    send_bits({16'h0, f}, 16);
    sel_off();
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    int unsigned seed_v;
    logic [15:0] f;
    seed_v = $urandom(32'd20517);
    model_reset();
    wait_n(5);
    chk("R1 reset code", code_near, 0);
    chk("R1 reset sdo", sdo_near, 0);
    chk("R1 reset count", cnt_near, 0);
    rst_n = 1'b1;
    wait_n(4);

    // directed codes with ignored filler and trailing bits (R3)
    frame({4'hF, 10'h3FF, 2'b11});
    chk("R3 full scale", code_near, 10'h3FF);
    frame({4'h0, 10'h000, 2'b00});
    frame({4'hA, 10'h200, 2'b01});
    chk("R3 midscale with filler", code_near, 10'h200);
    frame({4'h5, 10'h155, 2'b10});
    for (int k = 0; k < 12; k++) begin
      f = 16'($urandom);
      frame(f);
    end

    // clocking while deselected shifts nothing (R2, R8 hold)
    frame({4'h3, 10'h2A5, 2'b00});
    for (int k = 0; k < 5; k++) begin
      din = 1'($urandom);
      sclk = 1'b1; wait_n(8);
      sclk = 1'b0; wait_n(8);
      chk("R8 sdo held deselected", sdo_near, sdo_en);
      chk("R9 count held deselected", cnt_near, cnt_e);
    end
    sel_on();
    sel_off();
    chk("R2 no bits entered while high", code_near, 10'h2A5);

    // short and long frames (R5)
    sel_on();
    send_bits(32'h0000_02C7, 10);
    sel_off();
    chk("R5 short frame", code_near, code_of(m_near));
    sel_on();
    send_bits(32'h000A_BCDE, 20);
    chk("R9 count saturates", cnt_near, 16);
    sel_off();
    chk("R5 long frame last 16", code_near, 10'(16'hBCDE >> 2));

    // two-device chain, 32 bits in one window (R10)
    for (int k = 0; k < 3; k++) begin
      logic [31:0] w;
      w = (k == 0) ? {4'h0, 10'h123, 2'b00, 4'hF, 10'h3C8, 2'b00} : $urandom;
      sel_on();
      send_bits(w, 32);
      sel_off();
      chk("R10 far holds first half", code_far, 10'(w[31:16] >> 2));
      chk("R10 near holds last half", code_near, 10'(w[15:0] >> 2));
    end

    // asynchronous clear mid-frame with select low (R6)
    sel_on();
    send_bits(32'h0000_00AB, 8);
    @(negedge clk); #1;
    clr_n = 1'b0; #1;
    chk("R6 clear while selected near", code_near, 0);
    chk("R6 clear while selected far", code_far, 0);
    c_en = '0; c_ef = '0;
    wait_n(2);
    clr_n = 1'b1;
    send_bits(32'h0000_00CD, 8);
    sel_off();
    chk("R6 load after clear", code_near, 10'(16'hABCD >> 2));

    // clear with select high (R6)
    @(negedge clk); #1;
    clr_n = 1'b0; #1;
    chk("R6 clear while deselected", code_near, 0);
    wait_n(2);
    clr_n = 1'b1;
    c_en = '0; c_ef = '0;
    wait_n(2);

    // clear held across select rise (R7)
    sel_on();
    send_bits(32'h0000_7FFC, 16);
    clr_n = 1'b0;
    wait_n(2);
    sel_off();
    clr_n = 1'b1;
    wait_n(4);
    chk("R7 clear wins over load near", code_near, 0);
    chk("R7 clear wins over load far", code_far, 0);

    // power-on reset again forces zero (R1)
    frame({4'h0, 10'h1E1, 2'b00});
    rst_n = 1'b0;
    wait_n(2);
    chk("R1 reset clears loaded code", code_near, 0);
    chk("R1 reset clears sdo", sdo_near, 0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule